// File: doc/BRIEF.md
# I2C Bus Timing Parameter Search Engine

This block works out the five counter settings that an I2C master needs to shape its clock and data edges: a prescaler, a data-setup delay count, a data-hold delay count, and the SCL high and low counts. The caller gives it the period of the reference clock in nanoseconds and the bus rate wanted in hertz, then pulses `start_i`. From the rate the engine picks one of three speed classes (standard 100 kHz, fast 400 kHz, fast-plus 1 MHz). Each class brings its own set of bus timing limits. The engine then runs an exhaustive search, one candidate per clock cycle.

The search has two passes. The first pass walks every prescaler value. For each one it keeps the first setup/hold delay pair that meets the class's setup and hold-window limits, and writes it into an on-chip candidate table. The second pass walks the table entries. For each entry it sweeps the low and high counts and keeps the combination whose full SCL period is closest to the nominal period of the class. When the search ends, the packed 32-bit timing word and a valid flag are registered and `done_o` pulses for one cycle. All arithmetic is integer nanosecond products and compares.

Top module: `i2c_tsearch`

## Requirements
- R1: A rate selects a class only inside its inclusive ±20% band: 80000..120000 Hz gives standard, 320000..480000 Hz gives fast, 800000..1200000 Hz gives fast-plus. Any other rate ends the run with `valid_o`=0 and `timing_o`=0. The class limits in ns are as follows. Standard: nominal period 10000, period window 8333..12500, data-valid max 3450, setup min 250, low min 4700, high min 4000, rise 640, fall 20. Fast: 2500, 2083..3125, 900, 100, 1300, 600, 250, 100. Fast-plus: 1000, 833..1250, 450, 50, 500, 260, 60, 100.
- R2: Let T be the clock period and P the prescaler. For each P from 0 to 15, the first pass keeps the first pair found when the setup count D (0..15, outer) and the hold count H (0..15, inner) are scanned in ascending order. The pair must satisfy (D+1)(P+1)T ≥ rise + setup_min. It must also satisfy lo ≤ H(P+1)T ≤ hi, where lo = fall − 50 − 3T and hi = valid_max − rise − 260 − 4T, and each bound is clamped to 0 when it is not positive.
- R3: A low count L (0..255) is usable when low = 50 + 2T + (L+1)(P+1)T exceeds low_min and T < floor((low − 50)/4). A high count (0..255) gives high = 50 + 2T + (count+1)(P+1)T, which must be at least high_min and greater than T.
- R4: The period low + high + rise + fall must lie inside the class's period window. The result is the combination with the smallest absolute distance to the nominal period. A combination replaces the current best only if its distance is strictly smaller, starting from a distance equal to the nominal period. Ties keep the earliest combination in table order, then low count, then high count.
- R5: The timing word puts the prescaler at bits 31:28, the setup count at 23:20, the hold count at 19:16, the high count at 15:8 and the low count at 7:0. Bits 27:24 are zero.
- R6: When no combination qualifies, or the period input is 0, the run ends with `valid_o`=0 and `timing_o`=0.
- R7: `done_o` is high for exactly one cycle per run. `valid_o` and `timing_o` change only in that cycle and hold their values until the next run ends.
- R8: Inputs are sampled only when `start_i` is seen while idle. A start pulse during a run is ignored and does not change that run's result.
- R9: Every accepted start empties the candidate table, so each result depends only on that run's inputs.
- R10: After reset, `done_o`, `valid_o` and `timing_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a search when idle |
| tclk_ns_i | input | TCLK_W (16) | Reference clock period in ns |
| rate_hz_i | input | RATE_W (21) | Requested bus rate in Hz |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | Result word is usable |
| timing_o | output | 32 | Packed timing word |

## Verification
The bench builds the engine with its default widths: 4-bit prescaler and delay counts, 8-bit SCL counts and a 16-bit period. This makes the full 16×16×16 first pass and the 256×256 count sweep reachable, with words that match the packed layout exactly. Periods from 10 ns to 500 ns, used in each speed class, reach tables where every prescaler qualifies, hand-checkable results such as fast-plus at 100 ns, and runs where the second pass exits every entry at once. Rates placed on and just outside the band edges, a zero period, a start pulse mid-run and back-to-back runs test class selection, the invalid encoding, input capture and table clearing against an exhaustive reference search in the bench.

// File: rtl/i2c_tsearch_pkg.sv
package i2c_tsearch_pkg;

  localparam int NUM_MODES = 3;
  localparam logic [31:0] AF_MIN_NS = 32'd50;
  localparam logic [31:0] AF_MAX_NS = 32'd260;

  typedef struct packed {
    logic [31:0] rate_lo;
    logic [31:0] rate_hi;
    logic [31:0] nom;
    logic [31:0] pmin;
    logic [31:0] pmax;
    logic [31:0] vd_max;
    logic [31:0] su_min;
    logic [31:0] low_min;
    logic [31:0] high_min;
    logic [31:0] rise;
    logic [31:0] fall;
  } mode_lim_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_S1, ST_S2_LOAD, ST_S2_WAIT, ST_S2_LOW, ST_S2_HIGH, ST_FIN
  } search_st_e;

  function automatic mode_lim_t mode_limits(input int m);
    mode_lim_t l;
    case (m)
      0: l = '{32'd80000, 32'd120000, 32'd10000, 32'd8333, 32'd12500,
               32'd3450, 32'd250, 32'd4700, 32'd4000, 32'd640, 32'd20};
      1: l = '{32'd320000, 32'd480000, 32'd2500, 32'd2083, 32'd3125,
               32'd900, 32'd100, 32'd1300, 32'd600, 32'd250, 32'd100};
      default: l = '{32'd800000, 32'd1200000, 32'd1000, 32'd833, 32'd1250,
               32'd450, 32'd50, 32'd500, 32'd260, 32'd60, 32'd100};
    endcase
    return l;
  endfunction

endpackage

// File: rtl/i2c_tsearch_modesel.sv
module i2c_tsearch_modesel
  import i2c_tsearch_pkg::*;
#(
  parameter int RATE_W = 21
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic              hit_o,
  output mode_lim_t         lim_o
);
  logic [NUM_MODES-1:0] match;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_band
    mode_lim_t band;
    assign band = mode_limits(g);
    assign match[g] = (32'(rate_i) >= band.rate_lo) && (32'(rate_i) <= band.rate_hi);
  end

  always_comb begin
    hit_o = |match;
    lim_o = '0;
    for (int m = NUM_MODES - 1; m >= 0; m--) begin
      if (match[m]) lim_o = mode_limits(m);
    end
  end
endmodule

// File: rtl/i2c_tsearch_ctab.sv
module i2c_tsearch_ctab #(
  parameter int DEPTH = 16,
  parameter int W     = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_tsearch.sv
module i2c_tsearch
  import i2c_tsearch_pkg::*;
#(
  parameter int TCLK_W  = 16,
  parameter int RATE_W  = 21,
  parameter int PRESC_W = 4,
  parameter int DEL_W   = 4,
  parameter int SCL_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [TCLK_W-1:0] tclk_ns_i,
  input  logic [RATE_W-1:0] rate_hz_i,
  output logic              done_o,
  output logic              valid_o,
  output logic [31:0]       timing_o
);
  localparam int DEPTH = 1 << PRESC_W;
  localparam int ENT_W = PRESC_W + 2 * DEL_W;
  localparam int CNT_W = PRESC_W + 1;
  localparam logic [PRESC_W-1:0] P_LAST = '1;
  localparam logic [DEL_W-1:0]   D_LAST = '1;
  localparam logic [SCL_W-1:0]   C_LAST = '1;

  search_st_e         st_q;
  logic [31:0]        t_q;
  mode_lim_t          lim_q;
  logic               sel_hit;
  mode_lim_t          sel_lim;
  logic [CNT_W-1:0]   cnt_q;
  logic [PRESC_W-1:0] presc_q, idx_q, bp_q;
  logic [DEL_W-1:0]   scd_q, sda_q, bscd_q, bsda_q;
  logic [SCL_W-1:0]   scll_q, sclh_q, bl_q, bh_q;
  logic [ENT_W-1:0]   ent_q, rd_ent;
  logic [31:0]        tp_q, low_q, best_err_q;
  logic               found_q, busy;

  i2c_tsearch_modesel #(.RATE_W(RATE_W)) u_sel (
    .rate_i(rate_hz_i), .hit_o(sel_hit), .lim_o(sel_lim));

  // ---- first pass: one delay pair per prescaler ----
  logic [31:0] pt1, t_scd, t_sda, sda_lo, sda_hi, scl_need;
  logic        scd_ok, s1_hit, s1_next_scd, s1_next_p;
  always_comb begin
    pt1      = (32'(presc_q) + 32'd1) * t_q;
    t_scd    = (32'(scd_q) + 32'd1) * pt1;
    t_sda    = 32'(sda_q) * pt1;
    scl_need = lim_q.rise + lim_q.su_min;
    sda_lo   = (lim_q.fall > AF_MIN_NS + 32'd3 * t_q) ?
               lim_q.fall - AF_MIN_NS - 32'd3 * t_q : 32'd0;
    sda_hi   = (lim_q.vd_max > lim_q.rise + AF_MAX_NS + 32'd4 * t_q) ?
               lim_q.vd_max - lim_q.rise - AF_MAX_NS - 32'd4 * t_q : 32'd0;
    scd_ok   = t_scd >= scl_need;
    s1_hit   = scd_ok && (t_sda >= sda_lo) && (t_sda <= sda_hi);
    s1_next_scd = !s1_hit && (!scd_ok || sda_q == D_LAST);
    s1_next_p   = s1_hit || (s1_next_scd && scd_q == D_LAST);
  end

  i2c_tsearch_ctab #(.DEPTH(DEPTH), .W(ENT_W)) u_tab (
    .clk(clk), .we(st_q == ST_S1 && s1_hit), .waddr(cnt_q[PRESC_W-1:0]),
    .wdata({presc_q, scd_q, sda_q}), .raddr(idx_q), .rdata(rd_ent));

  // ---- second pass: low/high sweep ----
  logic [31:0] base, edge_t, low_c, high_c, tot0, tot, err;
  logic        low_ok, over, rec, adv_scll, adv_ent, last_ent;
  always_comb begin
    base   = AF_MIN_NS + 32'd2 * t_q;
    edge_t = lim_q.rise + lim_q.fall;
    low_c  = base + (32'(scll_q) + 32'd1) * tp_q;
    high_c = base + (32'(sclh_q) + 32'd1) * tp_q;
    tot0   = low_c + base + tp_q + edge_t;
    low_ok = (low_c > lim_q.low_min) && (t_q < ((low_c - AF_MIN_NS) >> 2));
    tot    = low_q + high_c + edge_t;
    err    = (tot >= lim_q.nom) ? tot - lim_q.nom : lim_q.nom - tot;
    over   = tot > lim_q.pmax;
    rec    = !over && (tot >= lim_q.pmin) && (high_c >= lim_q.high_min) &&
             (t_q < high_c) && (err < best_err_q);
    adv_scll = (st_q == ST_S2_LOW && tot0 <= lim_q.pmax && !low_ok) ||
               (st_q == ST_S2_HIGH && (over || sclh_q == C_LAST));
    adv_ent  = (st_q == ST_S2_LOW && tot0 > lim_q.pmax) ||
               (adv_scll && scll_q == C_LAST);
    last_ent = {1'b0, idx_q} == (cnt_q - CNT_W'(1));
  end

  assign busy = st_q != ST_IDLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; t_q <= '0; lim_q <= '0; cnt_q <= '0;
      presc_q <= '0; scd_q <= '0; sda_q <= '0; idx_q <= '0;
      ent_q <= '0; tp_q <= '0; low_q <= '0; scll_q <= '0; sclh_q <= '0;
      bp_q <= '0; bscd_q <= '0; bsda_q <= '0; bl_q <= '0; bh_q <= '0;
      best_err_q <= '0; found_q <= 1'b0;
      done_o <= 1'b0; valid_o <= 1'b0; timing_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          t_q <= 32'(tclk_ns_i);
          lim_q <= sel_lim;
          best_err_q <= sel_lim.nom;
          cnt_q <= '0; presc_q <= '0; scd_q <= '0; sda_q <= '0;
          found_q <= 1'b0;
          st_q <= (sel_hit && tclk_ns_i != '0) ? ST_S1 : ST_FIN;
        end
        ST_S1: begin
          if (s1_hit) cnt_q <= cnt_q + CNT_W'(1);
          if (s1_next_p) begin
            scd_q <= '0; sda_q <= '0;
            if (presc_q == P_LAST) begin
              idx_q <= '0;
              st_q <= ((cnt_q == '0) && !s1_hit) ? ST_FIN : ST_S2_LOAD;
            end else presc_q <= presc_q + 1'b1;
          end else if (s1_next_scd) begin
            scd_q <= scd_q + 1'b1; sda_q <= '0;
          end else sda_q <= sda_q + 1'b1;
        end
        ST_S2_LOAD: st_q <= ST_S2_WAIT;
        ST_S2_WAIT: begin
          ent_q  <= rd_ent;
          tp_q   <= (32'(rd_ent[ENT_W-1 -: PRESC_W]) + 32'd1) * t_q;
          scll_q <= '0;
          st_q   <= ST_S2_LOW;
        end
        ST_S2_LOW: if (tot0 <= lim_q.pmax && low_ok) begin
          low_q <= low_c; sclh_q <= '0; st_q <= ST_S2_HIGH;
        end
        ST_S2_HIGH: begin
          if (rec) begin
            bp_q   <= ent_q[ENT_W-1 -: PRESC_W];
            bscd_q <= ent_q[2*DEL_W-1 -: DEL_W];
            bsda_q <= ent_q[DEL_W-1:0];
            bh_q <= sclh_q; bl_q <= scll_q;
            best_err_q <= err; found_q <= 1'b1;
          end
          if (!over && sclh_q != C_LAST) sclh_q <= sclh_q + 1'b1;
        end
        ST_FIN: begin
          done_o   <= 1'b1;
          valid_o  <= found_q;
          timing_o <= found_q ? ((32'(bp_q) << 28) | (32'(bscd_q) << 20) |
                      (32'(bsda_q) << 16) | (32'(bh_q) << 8) | 32'(bl_q)) : 32'd0;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (adv_ent) begin
        if (last_ent) st_q <= ST_FIN;
        else begin idx_q <= idx_q + 1'b1; st_q <= ST_S2_LOAD; end
      end else if (adv_scll) begin
        scll_q <= scll_q + 1'b1; st_q <= ST_S2_LOW;
      end
    end
  end
endmodule

// File: rtl/i2c_tsearch_chk.sv
module i2c_tsearch_chk #(
  parameter int LAT_W = $bits(i2c_tsearch_pkg::mode_lim_t) + 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy,
  input logic [LAT_W-1:0] lat,
  input logic             done_o,
  input logic             valid_o,
  input logic [31:0]      timing_o
);
  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R7: results move only together with done
  assert_hold_results_R7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(valid_o) && $stable(timing_o)));
  // R6: an invalid result carries a zero word
  assert_invalid_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (done_o && !valid_o) |-> (timing_o == 32'd0));
  // R5: unused bits of the word stay clear
  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (timing_o[27:24] == 4'd0));
  // R8: an idle start always launches a run
  assert_leave_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_i) |=> busy);
  // R8: captured inputs stay fixed during a run
  assert_inputs_held_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(lat));
endmodule

bind i2c_tsearch i2c_tsearch_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy(busy), .lat({lim_q, t_q}),
  .done_o(done_o), .valid_o(valid_o), .timing_o(timing_o));

// File: tb/i2c_tsearch_tb.sv
module i2c_tsearch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LIMIT  = 60000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] tclk_ns_i = '0;
  logic [20:0] rate_hz_i = '0;
  logic        done_o, valid_o;
  logic [31:0] timing_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_tsearch dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .tclk_ns_i(tclk_ns_i),
    .rate_hz_i(rate_hz_i), .done_o(done_o), .valid_o(valid_o), .timing_o(timing_o));

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Exhaustive reference search written from the requirements.
  function automatic logic [32:0] model(input longint t, input longint rate);
    int m = -1;
    longint nom, pmin, pmax, vd, su, lw, hg, rs, fl, lo, hi, best, tp;
    int n = 0;
    int ep[16], ec[16], ed[16];
    logic ok = 1'b0;
    logic [31:0] w = '0;
    if (rate >= 80000 && rate <= 120000) m = 0;
    else if (rate >= 320000 && rate <= 480000) m = 1;
    else if (rate >= 800000 && rate <= 1200000) m = 2;
    if (m < 0 || t == 0) return 33'd0;
    case (m)
      0: begin nom=10000; pmin=8333; pmax=12500; vd=3450; su=250; lw=4700; hg=4000; rs=640; fl=20; end
      1: begin nom=2500; pmin=2083; pmax=3125; vd=900; su=100; lw=1300; hg=600; rs=250; fl=100; end
      default: begin nom=1000; pmin=833; pmax=1250; vd=450; su=50; lw=500; hg=260; rs=60; fl=100; end
    endcase
    lo = fl - 50 - 3 * t; if (lo < 0) lo = 0;
    hi = vd - rs - 260 - 4 * t; if (hi < 0) hi = 0;
    for (int p = 0; p < 16; p++) begin
      logic got = 1'b0;
      for (int c = 0; c < 16; c++)
        for (int d = 0; d < 16; d++)
          if (!got && (c + 1) * (p + 1) * t >= rs + su &&
              d * (p + 1) * t >= lo && d * (p + 1) * t <= hi) begin
            ep[n] = p; ec[n] = c; ed[n] = d; n++; got = 1'b1;
          end
    end
    best = nom;
    for (int e = 0; e < n; e++) begin
      tp = (ep[e] + 1) * t;
      for (int l = 0; l < 256; l++) begin
        longint low = 50 + 2 * t + (l + 1) * tp;
        if (low > lw && t < (low - 50) / 4)
          for (int h = 0; h < 256; h++) begin
            longint high = 50 + 2 * t + (h + 1) * tp;
            longint tot = low + high + rs + fl;
            longint er = (tot >= nom) ? tot - nom : nom - tot;
            if (tot >= pmin && tot <= pmax && high >= hg && t < high && er < best) begin
              best = er; ok = 1'b1;
              w = (32'(ep[e]) << 28) | (32'(ec[e]) << 20) | (32'(ed[e]) << 16) |
                  (32'(h) << 8) | 32'(l);
            end
          end
      end
    end
    return {ok, ok ? w : 32'd0};
  endfunction

  logic        got_valid;
  logic [31:0] got_word;

  task automatic run(input int t, input int rate, input string req);
    int waited = 0;
    @(negedge clk);
    tclk_ns_i = 16'(t); rate_hz_i = 21'(rate); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && waited < RUN_LIMIT) begin
      @(negedge clk); waited++;
    end
    check({req, " run completes"}, longint'(done_o), 1);
    got_valid = valid_o; got_word = timing_o;
    @(negedge clk);
    check("R7 done lasts one cycle", longint'(done_o), 0);
    check({req, " result held after done"}, longint'(timing_o), longint'(got_word));
  endtask

  task automatic run_vs_model(input int t, input int rate, input string req);
    logic [32:0] exp = model(t, rate);
    run(t, rate, req);
    check({req, " valid"}, longint'(got_valid), longint'(exp[32]));
    check({req, " word"}, longint'(got_word), longint'(exp[31:0]));
  endtask

  task automatic t_reset();
    check("R10 done after reset", longint'(done_o), 0);
    check("R10 valid after reset", longint'(valid_o), 0);
    check("R10 word after reset", longint'(timing_o), 0);
  endtask

  task automatic t_classes();
    run_vs_model(125, 100000, "R2 R3 R4 standard");
    run_vs_model(20, 400000, "R2 R4 fast");
    check("R5 fast reserved bits", longint'(got_word[27:24]), 0);
    run_vs_model(10, 1000000, "R3 R4 fast-plus");
  endtask

  task automatic t_hand_value();
    // 100 ns fast-plus: presc 0, setup 1, hold 0, high 0, low 2 -> period 1060
    run(100, 1000000, "R5 hand value");
    check("R3 R5 hand valid", longint'(got_valid), 1);
    check("R3 R5 hand word", longint'(got_word), 32'h0010_0002);
  endtask

  task automatic t_band_edges();
    run_vs_model(125, 80000, "R1 low edge standard");
    check("R1 80000 accepted", longint'(got_valid), 1);
    run(125, 79999, "R1 below band");
    check("R1 79999 rejected", longint'({got_valid, got_word}), 0);
    run(50, 480001, "R1 above fast band");
    check("R1 480001 rejected", longint'({got_valid, got_word}), 0);
    run_vs_model(10, 1200000, "R1 top edge fast-plus");
  endtask

  task automatic t_no_fit();
    run(500, 1000000, "R6 no fit");
    check("R6 no-fit valid", longint'(got_valid), 0);
    check("R6 no-fit word", longint'(got_word), 0);
    run(0, 400000, "R6 zero period");
    check("R6 zero period result", longint'({got_valid, got_word}), 0);
  endtask

  task automatic t_busy_ignore();
    logic [32:0] exp = model(20, 400000);
    int extra = 0;
    int waited = 0;
    @(negedge clk);
    tclk_ns_i = 16'd20; rate_hz_i = 21'd400000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (40) @(negedge clk);
    tclk_ns_i = 16'd125; rate_hz_i = 21'd100000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; tclk_ns_i = 16'd7; rate_hz_i = 21'd5;
    while (!done_o && waited < RUN_LIMIT) begin
      @(negedge clk); waited++;
    end
    check("R8 busy run completes", longint'(done_o), 1);
    check("R8 start during run ignored", longint'({valid_o, timing_o}), longint'(exp));
    repeat (200) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    check("R8 no second run launched", extra, 0);
  endtask

  task automatic t_back_to_back();
    run_vs_model(20, 400000, "R9 first run");
    run(100, 1000000, "R9 second run");
    check("R9 table cleared between runs", longint'(got_word), 32'h0010_0002);
    run_vs_model(40, 400000, "R9 third run");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_classes();
    t_hand_value();
    t_band_edges();
    t_no_fit();
    t_busy_ignore();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 199000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<199000 cycles", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule